// File: doc/BRIEF.md
# Broadcast Rank-1 Update Array

This block multiplies a 4-row operand A (4 x kc) by a 4-column operand B (kc x 4) and accumulates the result into a 4x4 matrix C. It does this as kc outer-product steps. On each step it takes one column of A and one row of B. Element i of the A column is driven onto a bus shared by all processing elements of row i. Element j of the B row is driven onto a bus shared by all elements of column j. Every element then adds the product of its two bus values to its own accumulator. All sixteen multiply-accumulates of a step happen in the same cycle, and C never leaves the array while the operands stream in.

A job opens with a start pulse that carries the length kc. The array then takes exactly kc valid operand beats and can take one beat per clock. It stalls on any cycle where valid is low, and it flags completion with a one-cycle done pulse. After that it presents the sixteen sums one per cycle, in row-major order, with their index. Operands are signed integers. Each accumulator is wide enough for the largest products summed over the longest job, so a sum can never overflow.

Top module: `rank1_array`

## Requirements
- R1: A start pulse accepted while the array is idle sets all sixteen accumulators to zero, so the results of a job contain only that job's products.
- R2: On each accepted beat, the element at row r and column c adds aCol[r*W +: W] times bRow[c*W +: W] to its accumulator, with both fields read as signed two's complement.
- R3: After a start with kcLen = k > 0, opReady is high until exactly k beats have been accepted (opValid high while opReady is high), and then it goes low.
- R4: done is high for exactly one cycle. That cycle is the one after the clock edge that accepted the last beat, and by then every accumulator includes that beat.
- R5: While opValid is low during a job, no accumulator changes, opReady stays high and done stays low. The job resumes when opValid returns.
- R6: Starting in the cycle after done, rdValid is high for 16 consecutive cycles. rdIdx counts 0 to 15 and rdData is the sum of the element at row rdIdx/4, column rdIdx%4.
- R7: A start pulse given while a job is streaming, finishing or reading out has no effect: the running job keeps its length and its sums, and the array returns to idle after readout.
- R8: With kcLen = 0, done is high in the cycle after the start, and all sixteen values read out are zero.
- R9: Accumulators are 2W + clog2(KC_MAX) bits wide, and sums of extreme operands (-2^(W-1) times -2^(W-1) on every beat) come out exact.
- R10: The array accepts a beat on every cycle of an uninterrupted stream, with opReady held high and no bubbles between beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a job when idle |
| kcLen | input | KCW | Number of rank-1 steps for the job (0 to KC_MAX) |
| opValid | input | 1 | An operand beat is present on aCol and bRow |
| aCol | input | DIM*W | One column of A, element r at bits r*W +: W |
| bRow | input | DIM*W | One row of B, element c at bits c*W +: W |
| opReady | output | 1 | The array is taking operand beats |
| done | output | 1 | One-cycle pulse after the last accumulate |
| rdValid | output | 1 | rdIdx and rdData carry a result |
| rdIdx | output | IDXW | Row-major index of the result shown |
| rdData | output | ACCW | Signed accumulated value |

## Verification
The assertions assume that kcLen never exceeds KC_MAX. They also assume that operand fields are held stable only while opValid is high, and that nothing depends on their value when the array is not ready. The no-overflow property assumes every accepted beat comes from a job within that length limit. The stimulus keeps every length at 64 or below. It changes inputs only at the falling edge and raises opValid only after the start has been taken. The stray start pulses it issues fall only in streaming or readout cycles, where the array must ignore them.

// File: rtl/rank1_pkg.sv
`timescale 1ns/1ps
package rank1_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN,
    ST_READ
  } r1State_e;

  typedef struct packed {
    logic clearAcc;
    logic macEn;
  } r1Strobe_t;
endpackage

// File: rtl/rank1_ctrl.sv
`timescale 1ns/1ps
module rank1_ctrl
  import rank1_pkg::*;
#(
  parameter int DIM  = 4,
  parameter int KCW  = 9,
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [KCW-1:0]  kcLen,
  input  logic            opValid,
  output r1Strobe_t       strobe,
  output logic            opReady,
  output logic            done,
  output logic            rdValid,
  output logic [IDXW-1:0] rdIdx
);
  localparam int LAST = DIM * DIM - 1;

  r1State_e        state;
  logic [KCW-1:0]  beatsLeft;
  logic [IDXW-1:0] readIdx;

  always_comb begin
    strobe.clearAcc = (state == ST_IDLE) && start;
    strobe.macEn    = (state == ST_RUN) && opValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      beatsLeft <= '0;
      readIdx   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          beatsLeft <= kcLen;
          state     <= (kcLen == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: if (opValid) begin
          beatsLeft <= beatsLeft - 1'b1;
          if (beatsLeft == KCW'(1)) state <= ST_FIN;
        end
        ST_FIN: begin
          readIdx <= '0;
          state   <= ST_READ;
        end
        default: begin
          readIdx <= readIdx + 1'b1;
          if (readIdx == IDXW'(LAST)) state <= ST_IDLE;
        end
      endcase
    end
  end

  assign opReady = (state == ST_RUN);
  assign done    = (state == ST_FIN);
  assign rdValid = (state == ST_READ);
  assign rdIdx   = readIdx;

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_last_beat_R3: assert property (@(posedge clk) disable iff (!rstN)
    (opReady && opValid && beatsLeft == KCW'(1)) |=> (done && !opReady));

  assert_stall_wait_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opReady && !opValid) |=> (opReady && !done));

  assert_read_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdIdx != IDXW'(LAST)) |=> (rdValid && rdIdx == IDXW'($past(rdIdx) + 1'b1)));

  assert_read_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && start) |=> !opReady);

  assert_run_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opReady && start && !opValid) |=> opReady);
endmodule

// File: rtl/rank1_pe.sv
`timescale 1ns/1ps
module rank1_pe
  import rank1_pkg::*;
#(
  parameter int W    = 16,
  parameter int ACCW = 40
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  r1Strobe_t              strobe,
  input  logic signed [W-1:0]    aIn,
  input  logic signed [W-1:0]    bIn,
  output logic signed [ACCW-1:0] acc
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] prodExt;

  assign prod    = aIn * bIn;
  assign prodExt = {{(ACCW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (!rstN)                acc <= '0;
    else if (strobe.clearAcc) acc <= '0;
    else if (strobe.macEn)    acc <= acc + prodExt;
  end

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAcc |=> (acc == '0));

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clearAcc && !strobe.macEn) |=> $stable(acc));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.macEn && !strobe.clearAcc && !prod[PW-1] && !acc[ACCW-1]) |=> !acc[ACCW-1]);
endmodule

// File: rtl/rank1_datapath.sv
`timescale 1ns/1ps
module rank1_datapath
  import rank1_pkg::*;
#(
  parameter int DIM  = 4,
  parameter int W    = 16,
  parameter int ACCW = 40,
  parameter int IDXW = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  r1Strobe_t          strobe,
  input  logic [DIM*W-1:0]   aCol,
  input  logic [DIM*W-1:0]   bRow,
  input  logic [IDXW-1:0]    rdIdx,
  output logic [ACCW-1:0]    rdData
);
  localparam int NPE = DIM * DIM;

  logic signed [W-1:0]    rowBus [DIM];
  logic signed [W-1:0]    colBus [DIM];
  logic signed [ACCW-1:0] accArr [NPE];

  for (genvar k = 0; k < DIM; k++) begin : g_bus
    assign rowBus[k] = aCol[k*W +: W];
    assign colBus[k] = bRow[k*W +: W];
  end

  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      rank1_pe #(.W(W), .ACCW(ACCW)) u_pe (
        .clk    (clk),
        .rstN   (rstN),
        .strobe (strobe),
        .aIn    (rowBus[r]),
        .bIn    (colBus[c]),
        .acc    (accArr[r*DIM + c])
      );
    end
  end

  assign rdData = accArr[rdIdx];
endmodule

// File: rtl/rank1_array.sv
`timescale 1ns/1ps
module rank1_array
  import rank1_pkg::*;
#(
  parameter int DIM    = 4,
  parameter int W      = 16,
  parameter int KC_MAX = 256,
  localparam int KCW   = $clog2(KC_MAX + 1),
  localparam int ACCW  = 2 * W + $clog2(KC_MAX),
  localparam int IDXW  = $clog2(DIM * DIM)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [KCW-1:0]   kcLen,
  input  logic             opValid,
  input  logic [DIM*W-1:0] aCol,
  input  logic [DIM*W-1:0] bRow,
  output logic             opReady,
  output logic             done,
  output logic             rdValid,
  output logic [IDXW-1:0]  rdIdx,
  output logic [ACCW-1:0]  rdData
);
  r1Strobe_t strobe;

  rank1_ctrl #(.DIM(DIM), .KCW(KCW), .IDXW(IDXW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .kcLen   (kcLen),
    .opValid (opValid),
    .strobe  (strobe),
    .opReady (opReady),
    .done    (done),
    .rdValid (rdValid),
    .rdIdx   (rdIdx)
  );

  rank1_datapath #(.DIM(DIM), .W(W), .ACCW(ACCW), .IDXW(IDXW)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .aCol   (aCol),
    .bRow   (bRow),
    .rdIdx  (rdIdx),
    .rdData (rdData)
  );
endmodule

// File: tb/rank1_array_bench.sv
`timescale 1ns/1ps
module rank1_array_bench;
  localparam int DIM = 4;
  localparam int W = 16;
  localparam int KC_MAX = 256;
  localparam int KCW = $clog2(KC_MAX + 1);
  localparam int ACCW = 2 * W + $clog2(KC_MAX);
  localparam int IDXW = $clog2(DIM * DIM);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [KCW-1:0] kcLen = '0;
  logic opValid = 1'b0;
  logic [DIM*W-1:0] aCol = '0;
  logic [DIM*W-1:0] bRow = '0;
  logic opReady, done, rdValid;
  logic [IDXW-1:0] rdIdx;
  logic [ACCW-1:0] rdData;

  int checks = 0;
  int fails = 0;
  int seedState = 32'h1234_5678;
  longint expQ[$];
  int expIdx = 0;
  int aMem [64][DIM];
  int bMem [64][DIM];

  always #4 clk = ~clk;

  rank1_array #(.DIM(DIM), .W(W), .KC_MAX(KC_MAX)) u_rank1_array (
    .clk(clk), .rstN(rstN), .start(start), .kcLen(kcLen), .opValid(opValid),
    .aCol(aCol), .bRow(bRow), .opReady(opReady), .done(done),
    .rdValid(rdValid), .rdIdx(rdIdx), .rdData(rdData)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nextVal();
    logic [15:0] t;
    seedState = seedState * 1103515245 + 12345;
    t = seedState[30:15];
    return int'($signed(t));
  endfunction

  // Scoreboard monitor: R2, R6 readout order and values
  always @(negedge clk) begin
    longint e;
    if (rstN && rdValid) begin
      if (expQ.size() == 0) check(1'b0, "R6 unexpected result", longint'(rdIdx), -1);
      else begin
        e = expQ.pop_front();
        check(int'(rdIdx) == expIdx, "R6 index", longint'(rdIdx), expIdx);
        check(longint'($signed(rdData)) == e, "R2 value", longint'($signed(rdData)), e);
      end
      expIdx = (expIdx + 1) % (DIM * DIM);
    end
  end

  task automatic runJob(input int kc, input int mode, input int stallEvery,
                        input bit runGlitch, input bit readGlitch);
    for (int p = 0; p < kc; p++) begin
      for (int k = 0; k < DIM; k++) begin
        case (mode)
          1: begin aMem[p][k] = -32768; bMem[p][k] = -32768; end
          2: begin aMem[p][k] = -32768; bMem[p][k] = (p % 2) ? -32768 : 32767; end
          default: begin aMem[p][k] = nextVal(); bMem[p][k] = nextVal(); end
        endcase
      end
    end
    for (int r = 0; r < DIM; r++) begin
      for (int c = 0; c < DIM; c++) begin
        longint s = 0;
        for (int p = 0; p < kc; p++) s += longint'(aMem[p][r]) * longint'(bMem[p][c]);
        expQ.push_back(s);
      end
    end
    expIdx = 0;
    @(negedge clk); start = 1'b1; kcLen = KCW'(kc);
    @(negedge clk); start = 1'b0;
    for (int p = 0; p < kc; p++) begin
      if (stallEvery > 0 && (p % stallEvery) == 1) begin
        opValid = 1'b0;
        @(negedge clk);
        check(opReady && !done, "R5 stall keeps job open", {opReady, done}, 2);
      end
      for (int k = 0; k < DIM; k++) begin
        aCol[k*W +: W] = aMem[p][k][15:0];
        bRow[k*W +: W] = bMem[p][k][15:0];
      end
      opValid = 1'b1;
      if (runGlitch && p == 1) begin start = 1'b1; kcLen = KCW'(2); end
      check(opReady == 1'b1, "R10 ready for beat", opReady, 1);
      @(negedge clk); start = 1'b0;
    end
    opValid = 1'b0;
    check(done == 1'b1, kc == 0 ? "R8 done after start" : "R4 done after last beat", done, 1);
    check(opReady == 1'b0, "R3 ready drops after kc beats", opReady, 0);
    for (int k = 0; k < DIM * DIM; k++) begin
      @(negedge clk);
      if (k == 0) check(done == 1'b0, "R4 done single cycle", done, 0);
      if (readGlitch && k == 5) begin start = 1'b1; kcLen = KCW'(3); end
      else start = 1'b0;
    end
    @(negedge clk); start = 1'b0;
    check(!rdValid && !opReady, "R7 idle after readout", {rdValid, opReady}, 0);
    check(expQ.size() == 0, "R6 sixteen results", expQ.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!opReady && !done && !rdValid, "reset state", {opReady, done, rdValid}, 0);
    runJob(1, 0, 0, 1'b0, 1'b0);          // R2 single step
    runJob(4, 0, 0, 1'b0, 1'b0);          // R1 new job clears, R10 full rate
    runJob(0, 0, 0, 1'b0, 1'b0);          // R8 empty job
    runJob(16, 0, 3, 1'b0, 1'b0);         // R5 stalls
    runJob(8, 0, 0, 1'b1, 1'b0);          // R7 start while streaming
    runJob(6, 0, 0, 1'b0, 1'b1);          // R7 start during readout
    runJob(64, 1, 0, 1'b0, 1'b0);         // R9 extreme positive sums
    runJob(33, 2, 5, 1'b0, 1'b0);         // R9 mixed extremes with stalls
    runJob(2, 0, 0, 1'b0, 1'b0);          // R1 clear after a large job
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule